// File: doc/BRIEF.md
# PHY Event Interrupt Controller

This block gathers seven link-status conditions from a 10/100 Ethernet physical-layer core and turns them into one active-low interrupt line for the host. Each condition arrives as a level. The block detects the transition that marks the event and latches it into a bit of a flag register. Six of the conditions count as events when they rise. Link status counts as an event when it falls, which means the link was lost. A mask register selects which flags may pull the interrupt line low.

The controller releases the interrupt in one of two ways, chosen by a mode register. In clear-on-read mode, a read of the flag register returns the pending flags and then empties the register. In level-follow mode, each flag drops by itself as soon as its source goes back to its idle level, and a read does not change any flag. Events are detected and set in the same way in both modes.

All three registers sit behind a small synchronous read/write port. Read data is combinational from the addressed register.

Top module: `phy_evt_irq`

## Requirements
- R1: After reset the flag register, the mask register and the mode bit are all zero, and `irq_n` is high.
- R2: Flag bits are assigned as follows: bit 7 energy present (`src[6]`), bit 6 negotiation done (`src[5]`), bit 5 far-end fault (`src[4]`), bit 4 link status (`src[3]`), bit 3 base page acknowledged (`src[2]`), bit 2 parallel-detect fault (`src[1]`), bit 1 new page (`src[0]`). Bit 0 and bits 15:8 always read as zero.
- R3: Every source except link status sets its flag on a 0-to-1 transition. A source that stays high does not set its flag again after the flag has been cleared.
- R4: Link status (`src[3]`) sets its flag on a 1-to-0 transition. Its 0-to-1 transition sets nothing.
- R5: `irq_n` is low exactly when at least one flag is set whose mask bit is also set. A masked event is still latched in the flag register.
- R6: In clear-on-read mode (mode bit 0 = 0), a read at address 0 returns the current flags and clears them on that clock edge, so `irq_n` returns high.
- R7: An event detected on the same clock edge as a clearing read is kept in the flag register.
- R8: In level-follow mode (mode bit 0 = 1), a flag clears when its source returns to idle. Idle is low for every source except link status, whose idle level is high. Reads do not clear flags in this mode.
- R9: The register map is: address 0 holds the flags and ignores writes; address 1 holds the mask, with bits 7:1 writable and all other bits reading zero; address 2 holds the mode in bit 0; address 3 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src | input | 7 | Level status inputs; index i maps to flag bit i+1 |
| reg_addr | input | 2 | Register select |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe; a read at address 0 may clear flags |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data from the addressed register |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The bench targets the following corner cases:

- **Inverted link polarity.** A link source that rises and later falls must report only the fall. A design with the polarity wrong would flag link-up instead of link-down.
- **Levels held high.** Sources are held high across a clearing read. A level detector in place of an edge detector would keep re-raising those flags.
- **Event during a clearing read.** A source changes on the exact edge of a clearing read. A design that gives the clear priority would silently drop that event.
- **Mask behaviour.** Masked events must stay latched while `irq_n` stays quiet.
- **Level-follow mode.** The bench reads twice in this mode to show that reads do not clear flags. It then returns each source to idle, including the link source, whose idle level is high, and expects the flag to drop.
- **Register map.** Writes to the flag address must be ignored, and stray mask bits must read as zero.

// File: rtl/phy_evt_pkg.sv
package phy_evt_pkg;

  localparam int unsigned REG_ADDR_W = 2;

  typedef enum logic [REG_ADDR_W-1:0] {
    SEL_FLAGS = 2'd0,
    SEL_MASK  = 2'd1,
    SEL_MODE  = 2'd2,
    SEL_SPARE = 2'd3
  } reg_sel_e;

endpackage

// File: rtl/phy_evt_edge.sv
// Per-source transition detector. A source is "active" when it differs
// from its idle level; an event is the first cycle it is seen active.
module phy_evt_edge #(
  parameter int unsigned     N_SRC   = 7,
  parameter logic [N_SRC-1:0] IDLE_HI = 7'b0001000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src,
  output logic [N_SRC-1:0] active,
  output logic [N_SRC-1:0] evt
);

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    logic prev_q;
    logic prev_d;

    assign active[i] = src[i] ^ IDLE_HI[i];

    always_comb begin
      prev_d = active[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= prev_d;
    end

    assign evt[i] = active[i] & ~prev_q;
  end

  // R3
  evt_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0) |=> ((evt & $past(evt)) == '0));

endmodule

// File: rtl/phy_evt_flags.sv
// Sticky event flags with the two release policies.
module phy_evt_flags #(
  parameter int unsigned N_SRC = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] evt,
  input  logic [N_SRC-1:0] active,
  input  logic             alt_mode,
  input  logic             rd_clr,
  output logic [N_SRC-1:0] flags
);

  logic [N_SRC-1:0] flags_q;
  logic [N_SRC-1:0] flags_d;

  always_comb begin
    for (int i = 0; i < N_SRC; i++) begin
      if (alt_mode) flags_d[i] = evt[i] | (flags_q[i] & active[i]);
      else          flags_d[i] = evt[i] | (flags_q[i] & ~rd_clr);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  assign flags = flags_q;

  // R7
  evt_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0) |=> ((flags & $past(evt)) == $past(evt)));

  // R6
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && !alt_mode && evt == '0) |=> (flags == '0));

  // R8
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alt_mode |=> ((flags & ~$past(active)) == '0));

endmodule

// File: rtl/phy_evt_regs.sv
// Mask and mode registers, read mux and clear-on-read strobe.
module phy_evt_regs
  import phy_evt_pkg::*;
#(
  parameter int unsigned N_SRC  = 7,
  parameter int unsigned DATA_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [REG_ADDR_W-1:0] addr,
  input  logic                  wr,
  input  logic                  rd,
  input  logic [DATA_W-1:0]     wdata,
  input  logic [N_SRC-1:0]      flags,
  output logic [N_SRC-1:0]      mask,
  output logic                  alt_mode,
  output logic                  rd_clr,
  output logic [DATA_W-1:0]     rdata
);

  localparam int unsigned FLAG_LO = 1;
  localparam int unsigned FLAG_HI = FLAG_LO + N_SRC - 1;

  reg_sel_e sel;
  assign sel = reg_sel_e'(addr);

  logic [N_SRC-1:0] mask_q, mask_d;
  logic             mask_we;
  logic             mode_q, mode_d;
  logic             mode_we;

  always_comb begin
    mask_we = wr && (sel == SEL_MASK);
    mode_we = wr && (sel == SEL_MODE);
    mask_d  = wdata[FLAG_HI:FLAG_LO];
    mode_d  = wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_we) mask_q <= mask_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= 1'b0;
    else if (mode_we) mode_q <= mode_d;
  end

  logic unused_wbits;
  assign unused_wbits = ^wdata[DATA_W-1:FLAG_HI+1];

  always_comb begin
    rdata = '0;
    unique case (sel)
      SEL_FLAGS: rdata[FLAG_HI:FLAG_LO] = flags;
      SEL_MASK:  rdata[FLAG_HI:FLAG_LO] = mask_q;
      SEL_MODE:  rdata[0]               = mode_q;
      default:   rdata                  = '0;
    endcase
  end

  assign rd_clr   = rd && (sel == SEL_FLAGS);
  assign mask     = mask_q;
  assign alt_mode = mode_q;

endmodule

// File: rtl/phy_evt_irq.sv
module phy_evt_irq
  import phy_evt_pkg::*;
#(
  parameter int unsigned      N_SRC   = 7,
  parameter int unsigned      DATA_W  = 16,
  parameter logic [N_SRC-1:0] IDLE_HI = 7'b0001000
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [N_SRC-1:0]      src,
  input  logic [REG_ADDR_W-1:0] reg_addr,
  input  logic                  reg_wr,
  input  logic                  reg_rd,
  input  logic [DATA_W-1:0]     reg_wdata,
  output logic [DATA_W-1:0]     reg_rdata,
  output logic                  irq_n
);

  logic [N_SRC-1:0] active;
  logic [N_SRC-1:0] evt;
  logic [N_SRC-1:0] flags;
  logic [N_SRC-1:0] mask;
  logic             alt_mode;
  logic             rd_clr;

  phy_evt_edge #(.N_SRC(N_SRC), .IDLE_HI(IDLE_HI)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .src    (src),
    .active (active),
    .evt    (evt)
  );

  phy_evt_flags #(.N_SRC(N_SRC)) u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt      (evt),
    .active   (active),
    .alt_mode (alt_mode),
    .rd_clr   (rd_clr),
    .flags    (flags)
  );

  phy_evt_regs #(.N_SRC(N_SRC), .DATA_W(DATA_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (reg_addr),
    .wr       (reg_wr),
    .rd       (reg_rd),
    .wdata    (reg_wdata),
    .flags    (flags),
    .mask     (mask),
    .alt_mode (alt_mode),
    .rd_clr   (rd_clr),
    .rdata    (reg_rdata)
  );

  assign irq_n = ~|(flags & mask);

  // R5
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> irq_n);

endmodule

// File: tb/tb_phy_evt_irq.sv
`timescale 1ns/1ps
module tb_phy_evt_irq;

  localparam real HALF = 2.5;

  logic        clk;
  logic        rst_n;
  logic [6:0]  src;
  logic [1:0]  reg_addr;
  logic        reg_wr;
  logic        reg_rd;
  logic [15:0] reg_wdata;
  logic [15:0] reg_rdata;
  logic        irq_n;

  phy_evt_irq dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .src       (src),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq_n     (irq_n)
  );

  initial clk = 1'b0;
  always #(HALF) clk = ~clk;

  // scoreboard queues: kind 0 = read data, kind 1 = irq_n
  int          q_kind[$];
  logic [15:0] q_val[$];
  string       q_tag[$];
  event        chk_ev;
  int          n_vec  = 0;
  int          n_fail = 0;
  bit          done   = 1'b0;

  initial begin
    forever begin
      @(chk_ev);
      while (q_kind.size() > 0) begin
        int          k;
        logic [15:0] e;
        logic [15:0] a;
        string       t;
        k = q_kind.pop_front();
        e = q_val.pop_front();
        t = q_tag.pop_front();
        a = (k == 0) ? reg_rdata : {15'b0, irq_n};
        n_vec++;
        if (a !== e) begin
          n_fail++;
          $display("FAIL %s: %s actual=%h expected=%h", t,
                   (k == 0) ? "rdata" : "irq_n", a, e);
        end
      end
    end
  end

  task automatic push(input int k, input logic [15:0] v, input string t);
    q_kind.push_back(k);
    q_val.push_back(v);
    q_tag.push_back(t);
    ->chk_ev;
  endtask

  task automatic set_src(input logic [6:0] v);
    @(negedge clk);
    src = v;
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [1:0] a, input logic [15:0] e, input string t);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 push(0, e, t);
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  // read of the flag register on the same edge as a source change
  task automatic rd_chk_src(input logic [15:0] e, input logic [6:0] v, input string t);
    @(negedge clk);
    reg_addr = 2'd0; reg_rd = 1'b1; src = v;
    #1 push(0, e, t);
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic irq_chk(input logic e, input string t);
    @(negedge clk);
    #1 push(1, {15'b0, e}, t);
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
  endtask

  initial begin
    #(HALF * 2 * 20000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; src = 7'b0001000; reg_addr = '0;
    reg_wr = 1'b0; reg_rd = 1'b0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    irq_chk(1'b1, "R1 irq idle");
    rd_chk(2'd0, 16'h0000, "R1 flags zero");
    rd_chk(2'd1, 16'h0000, "R1 mask zero");
    rd_chk(2'd2, 16'h0000, "R1 mode zero");

    // R3/R2: six rising sources, masked off (R5)
    set_src(7'b1111111);
    irq_chk(1'b1, "R5 all masked");
    rd_chk(2'd0, 16'h00EE, "R3 R2 rising flags");
    rd_chk(2'd0, 16'h0000, "R3 held level no re-set");

    // R4 link polarity
    set_src(7'b1110111);
    rd_chk(2'd0, 16'h0010, "R4 link fall");
    set_src(7'b1111111);
    rd_chk(2'd0, 16'h0000, "R4 link rise ignored");

    // R9 register map
    wr_reg(2'd1, 16'hFFFF);
    rd_chk(2'd1, 16'h00FE, "R9 mask bits");
    wr_reg(2'd0, 16'hFFFF);
    rd_chk(2'd0, 16'h0000, "R9 flag write ignored");
    rd_chk(2'd3, 16'h0000, "R9 spare reads zero");
    irq_chk(1'b1, "R9 irq after flag write");

    // R5/R6 unmasked event and clear on read
    set_src(7'b0001000);
    set_src(7'b0001001);
    irq_chk(1'b0, "R5 unmasked event");
    rd_chk(2'd0, 16'h0002, "R6 read flags");
    irq_chk(1'b1, "R6 released by read");

    // R5 masked event latched but quiet
    wr_reg(2'd1, 16'h0004);
    set_src(7'b0001000);
    set_src(7'b0001001);
    irq_chk(1'b1, "R5 masked quiet");
    rd_chk(2'd0, 16'h0002, "R5 masked latched");
    set_src(7'b0001011);
    irq_chk(1'b0, "R5 enabled source");
    rd_chk(2'd0, 16'h0004, "R6 read pd fault");
    irq_chk(1'b1, "R6 release");

    // R7 event coinciding with clearing read
    rd_chk_src(16'h0000, 7'b1001011, "R7 read during event");
    rd_chk(2'd0, 16'h0080, "R7 event kept");

    // R8 level-follow mode
    wr_reg(2'd2, 16'h0001);
    rd_chk(2'd2, 16'h0001, "R9 mode bit");
    wr_reg(2'd1, 16'h00FE);
    set_src(7'b1101011);
    irq_chk(1'b0, "R8 event asserts");
    rd_chk(2'd0, 16'h0040, "R8 first read");
    rd_chk(2'd0, 16'h0040, "R8 read does not clear");
    irq_chk(1'b0, "R8 still asserted");
    set_src(7'b1001011);
    irq_chk(1'b1, "R8 idle releases");
    rd_chk(2'd0, 16'h0000, "R8 flag dropped");
    set_src(7'b1000011);
    irq_chk(1'b0, "R8 link fall asserts");
    rd_chk(2'd0, 16'h0010, "R8 link flag");
    set_src(7'b1001011);
    irq_chk(1'b1, "R8 link up releases");
    rd_chk(2'd0, 16'h0000, "R8 link flag dropped");

    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule